// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer with 3½-Digit BCD Result

This block is the digital half of a dual-slope integrating analog-to-digital converter. It runs a fixed cycle over and over. First comes an auto-zero phase of a set number of clocks. Then the input is charged onto the integrator for a fixed window of clocks. Last, a reference of the opposite polarity discharges the integrator while a BCD counter advances once per clock. The counter stops when the comparator reports that the integrator is back at zero. The count at that moment is the reading, equal to the integration length times Vin/Vref. With the default 1000-clock window it reads 0 to 1999, so full scale is twice the reference.

When the count stops, it is copied into output registers along with the polarity of the input, which is sampled as integration ends. A one-cycle strobe marks each copy. The outputs therefore only ever show completed conversions. If the comparator has not tripped when the counter reaches its top value, the discharge is cut short, the top value is copied and an overrange flag is raised. The comparator input comes from the analog domain, so it passes through a two-flop synchronizer before the controller uses it.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset the phases run in the order auto-zero, integrate, deintegrate, then auto-zero again, repeating with no end. Exactly one of swAutoZero, swIntegrate and swDeint is high in every cycle, and auto-zero lasts exactly AZ_CLKS cycles.
- R2: swIntegrate stays high for exactly INT_CLKS consecutive cycles in every conversion.
- R3: refNeg is high only during deintegration, and only when the sign sampled at the end of integration was positive (signIn = 0). The block selects the reference of the opposite polarity to the input.
- R4: The reading counts the deintegration clocks with two cycles of synchronizer latency. If cmpZero rises during deintegration cycle j (cycle 0 is the first; j = -1 and j = -2 are the last two integration cycles), the reading is j+2, as long as j+2 <= MAXV, where MAXV = 2*10^NUM_DIGITS - 1.
- R5: The reading is BCD. Nibble i of dispDigits (nibble 0 in bits 3:0) holds decimal digit i, counting from the units. dispHalf is the leading digit and is 0 or 1. No nibble ever holds a value above 9.
- R6: If the comparator has not been seen high when the count equals MAXV, deintegration ends in that cycle, MAXV is latched and overRange is 1. The next conversion that ends normally latches overRange back to 0.
- R7: latchStb is a single-cycle pulse. It comes in the cycle after deintegration stops, which is also the first auto-zero cycle. The outputs dispDigits, dispHalf, dispNeg and overRange change only in a strobe cycle.
- R8: dispNeg latches the signIn value present on the last integration cycle. A change on signIn during deintegration has no effect on that conversion.
- R9: While rst is held, swAutoZero is 1 and swIntegrate, swDeint, refNeg, latchStb, dispDigits, dispHalf, dispNeg and overRange are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpZero | input | 1 | Comparator output, high once the integrator has returned to zero (asynchronous) |
| signIn | input | 1 | Input polarity, 1 = negative |
| swAutoZero | output | 1 | Auto-zero switch control |
| swIntegrate | output | 1 | Input-to-integrator switch control |
| swDeint | output | 1 | Reference-to-integrator switch control |
| refNeg | output | 1 | Selects the negative reference during deintegration |
| latchStb | output | 1 | One-cycle pulse when a new reading is latched |
| dispDigits | output | 4*NUM_DIGITS | Latched BCD digits, units in bits 3:0 |
| dispHalf | output | 1 | Latched leading half digit |
| dispNeg | output | 1 | Latched polarity of the reading |
| overRange | output | 1 | Latched overrange flag |

## Verification
The bench builds the block with AZ_CLKS = 4, INT_CLKS = 8 and NUM_DIGITS = 2, which gives a top reading of 199. With these values it can run one full conversion for every comparator trip point, from two cycles before deintegration starts through the last count, plus the trip points that cause overrange and a run where the comparator never trips. It works out each expected reading, its BCD encoding, the strobe cycle and the latched sign from the trip cycle alone. The short phases make every carry across digit boundaries and the top-of-range cutoff quick to reach.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic grabSign;
    logic latchCnt;
    logic latchOvr;
  } dpCtl_t;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int AZ_CLKS  = 1000,
  parameter int INT_CLKS = 1000
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   zeroSync,
  input  logic   atMax,
  output phase_e phase,
  output dpCtl_t ctl
);
  localparam int PH_MAX = (AZ_CLKS > INT_CLKS) ? AZ_CLKS : INT_CLKS;
  localparam int PCW    = $clog2(PH_MAX);

  logic [PCW-1:0] pcnt;
  logic           lastAz, lastInt, stopNow;

  assign lastAz  = (pcnt == PCW'(AZ_CLKS - 1));
  assign lastInt = (pcnt == PCW'(INT_CLKS - 1));
  assign stopNow = zeroSync || atMax;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_AZ;
      pcnt  <= '0;
    end else begin
      unique case (phase)
        PH_AZ: begin
          if (lastAz) begin
            phase <= PH_INT;
            pcnt  <= '0;
          end else pcnt <= pcnt + 1'b1;
        end
        PH_INT: begin
          if (lastInt) begin
            phase <= PH_DEINT;
            pcnt  <= '0;
          end else pcnt <= pcnt + 1'b1;
        end
        PH_DEINT: begin
          if (stopNow) begin
            phase <= PH_AZ;
            pcnt  <= '0;
          end
        end
        default: begin
          phase <= PH_AZ;
          pcnt  <= '0;
        end
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.clrCnt   = (phase == PH_INT);
    ctl.grabSign = (phase == PH_INT) && lastInt;
    if (phase == PH_DEINT) begin
      if (zeroSync) begin
        ctl.latchCnt = 1'b1;
      end else if (atMax) begin
        ctl.latchCnt = 1'b1;
        ctl.latchOvr = 1'b1;
      end else begin
        ctl.incCnt = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsadc_dp.sv
module dsadc_dp
  import dsadc_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpCtl_t                  ctl,
  input  logic                    signIn,
  output logic                    atMax,
  output logic                    signHeld,
  output logic                    latchStb,
  output logic [4*NUM_DIGITS-1:0] dispDigits,
  output logic                    dispHalf,
  output logic                    dispNeg,
  output logic                    overRange
);
  localparam int DW = 4 * NUM_DIGITS;

  logic [NUM_DIGITS-1:0][3:0] cnt, cntNext;
  logic [NUM_DIGITS:0]        carry;
  logic [NUM_DIGITS-1:0]      isNine;
  logic                       half;

  assign carry[0] = ctl.incCnt;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    assign isNine[i]    = (cnt[i] == 4'd9);
    assign carry[i+1]   = carry[i] && isNine[i];
    assign cntNext[i]   = !carry[i] ? cnt[i] : (isNine[i] ? 4'd0 : cnt[i] + 4'd1);
  end

  assign atMax = half && (&isNine);

  always_ff @(posedge clk) begin
    if (rst || ctl.clrCnt) begin
      cnt  <= '0;
      half <= 1'b0;
    end else begin
      cnt  <= cntNext;
      half <= half | carry[NUM_DIGITS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               signHeld <= 1'b0;
    else if (ctl.grabSign) signHeld <= signIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latchStb   <= 1'b0;
      dispDigits <= '0;
      dispHalf   <= 1'b0;
      dispNeg    <= 1'b0;
      overRange  <= 1'b0;
    end else begin
      latchStb <= ctl.latchCnt;
      if (ctl.latchCnt) begin
        dispDigits <= DW'(cnt);
        dispHalf   <= half;
        dispNeg    <= signHeld;
        overRange  <= ctl.latchOvr;
      end
    end
  end
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int AZ_CLKS     = 1000,
  parameter int INT_CLKS    = 1000,
  parameter int NUM_DIGITS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmpZero,
  input  logic                    signIn,
  output logic                    swAutoZero,
  output logic                    swIntegrate,
  output logic                    swDeint,
  output logic                    refNeg,
  output logic                    latchStb,
  output logic [4*NUM_DIGITS-1:0] dispDigits,
  output logic                    dispHalf,
  output logic                    dispNeg,
  output logic                    overRange
);
  phase_e phase;
  dpCtl_t ctl;
  logic   zeroSync, atMax, signHeld;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cmpZero),
    .dout(zeroSync)
  );

  dsadc_seq #(.AZ_CLKS(AZ_CLKS), .INT_CLKS(INT_CLKS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .zeroSync(zeroSync),
    .atMax   (atMax),
    .phase   (phase),
    .ctl     (ctl)
  );

  dsadc_dp #(.NUM_DIGITS(NUM_DIGITS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .signIn    (signIn),
    .atMax     (atMax),
    .signHeld  (signHeld),
    .latchStb  (latchStb),
    .dispDigits(dispDigits),
    .dispHalf  (dispHalf),
    .dispNeg   (dispNeg),
    .overRange (overRange)
  );

  assign swAutoZero  = (phase == PH_AZ);
  assign swIntegrate = (phase == PH_INT);
  assign swDeint     = (phase == PH_DEINT);
  assign refNeg      = swDeint && !signHeld;
endmodule

// File: rtl/dsadc_chk.sv
module dsadc_chk #(
  parameter int INT_CLKS   = 1000,
  parameter int NUM_DIGITS = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    swAutoZero,
  input logic                    swIntegrate,
  input logic                    swDeint,
  input logic                    refNeg,
  input logic                    latchStb,
  input logic [4*NUM_DIGITS-1:0] dispDigits,
  input logic                    dispHalf,
  input logic                    dispNeg,
  input logic                    overRange
);
  function automatic logic [4*NUM_DIGITS-1:0] allNines();
    logic [4*NUM_DIGITS-1:0] v;
    for (int i = 0; i < NUM_DIGITS; i++) v[4*i +: 4] = 4'd9;
    return v;
  endfunction

  localparam logic [4*NUM_DIGITS-1:0] NINES = allNines();

  int intRun;
  always_ff @(posedge clk) begin
    if (rst)              intRun <= 0;
    else if (swIntegrate) intRun <= intRun + 1;
    else                  intRun <= 0;
  end

  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({swAutoZero, swIntegrate, swDeint}) == 1);

  // R2
  int_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(swIntegrate) |-> intRun == INT_CLKS);

  // R3
  ref_only_deint_chk: assert property (@(posedge clk) disable iff (rst)
    refNeg |-> swDeint);

  // R7
  stb_after_deint_chk: assert property (@(posedge clk) disable iff (rst)
    latchStb |-> $past(swDeint) && swAutoZero);

  // R7
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    latchStb |=> !latchStb);

  // R7
  disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latchStb |-> $stable({dispDigits, dispHalf, dispNeg, overRange}));

  // R6
  ovr_full_chk: assert property (@(posedge clk) disable iff (rst)
    overRange |-> dispHalf && dispDigits == NINES);

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    // R5
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      dispDigits[4*i +: 4] <= 4'd9);
  end
endmodule

bind dsadc_ctrl dsadc_chk #(.INT_CLKS(INT_CLKS), .NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .swAutoZero (swAutoZero),
  .swIntegrate(swIntegrate),
  .swDeint    (swDeint),
  .refNeg     (refNeg),
  .latchStb   (latchStb),
  .dispDigits (dispDigits),
  .dispHalf   (dispHalf),
  .dispNeg    (dispNeg),
  .overRange  (overRange)
);

// File: tb/dsadc_ctrl_bench.sv
`timescale 1ns/1ps
module dsadc_ctrl_bench;
  localparam int AZ   = 4;
  localparam int INTC = 8;
  localparam int ND   = 2;
  localparam int MAXV = 2 * (10 ** ND) - 1;
  localparam int DW   = 4 * ND;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmpZero = 1'b0;
  logic signIn = 1'b0;
  logic swAutoZero, swIntegrate, swDeint, refNeg, latchStb;
  logic [DW-1:0] dispDigits;
  logic dispHalf, dispNeg, overRange;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  dsadc_ctrl #(.AZ_CLKS(AZ), .INT_CLKS(INTC), .NUM_DIGITS(ND)) u_dsadc_ctrl (
    .clk(clk), .rst(rst), .cmpZero(cmpZero), .signIn(signIn),
    .swAutoZero(swAutoZero), .swIntegrate(swIntegrate), .swDeint(swDeint),
    .refNeg(refNeg), .latchStb(latchStb), .dispDigits(dispDigits),
    .dispHalf(dispHalf), .dispNeg(dispNeg), .overRange(overRange)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] toBcd(input int v);
    logic [DW-1:0] r;
    for (int i = 0; i < ND; i++) r[4*i +: 4] = 4'((v / (10 ** i)) % 10);
    return r;
  endfunction

  // one conversion; entered at a negedge in auto-zero cycle 0
  task automatic runConv(input int j, input bit sgn);
    int azCnt, idx, intCnt, refBad, stbIdx, expRead, expIdx;
    bit expOvr;
    azCnt = 1;
    signIn = sgn;
    @(negedge clk);
    while (swAutoZero && azCnt < AZ + 10) begin
      azCnt++;
      @(negedge clk);
    end
    check(azCnt == AZ && swIntegrate, "R1 auto-zero length", azCnt, AZ);
    idx = 0; intCnt = 0; refBad = 0; stbIdx = -1;
    while (idx < INTC + MAXV + 10) begin
      if (swIntegrate) intCnt++;
      if (refNeg != (swDeint && !sgn)) refBad++;
      if (idx == INTC + j) cmpZero = 1'b1;
      if (idx == INTC) signIn = !sgn;
      if (latchStb) begin
        stbIdx = idx;
        break;
      end
      @(negedge clk);
      idx++;
    end
    expOvr  = (j + 2 > MAXV);
    expRead = expOvr ? MAXV : j + 2;
    expIdx  = expOvr ? INTC + MAXV + 1 : INTC + j + 3;
    check(intCnt == INTC, "R2 integrate length", intCnt, INTC);
    check(refBad == 0, "R3 reference select", refBad, 0);
    check(stbIdx == expIdx, "R7 strobe cycle", stbIdx, expIdx);
    check(dispDigits == toBcd(expRead) && dispHalf == (expRead >= 10 ** ND),
          expOvr ? "R6 clamped reading" : "R4 R5 reading",
          {dispHalf, dispDigits}, {(expRead >= 10 ** ND), toBcd(expRead)});
    check(overRange == expOvr, "R6 overrange flag", overRange, expOvr);
    check(dispNeg == sgn, "R8 latched sign", dispNeg, sgn);
    cmpZero = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(swAutoZero && !swIntegrate && !swDeint && !refNeg && !latchStb,
          "R9 reset switches", {swAutoZero, swIntegrate, swDeint, refNeg, latchStb}, 5'b10000);
    check(dispDigits == '0 && !dispHalf && !dispNeg && !overRange,
          "R9 reset display", {dispHalf, dispDigits, dispNeg, overRange}, 0);
    rst = 1'b0;
    for (int j = -2; j <= MAXV - 1; j++) runConv(j, j[0]);
    runConv(MAXV + 50, 1'b1);   // comparator never trips
    runConv(5, 1'b0);           // overRange must clear again
    runConv(MAXV - 2, 1'b1);    // exact top reading
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule